// File: doc/BRIEF.md
# Read Request Splitter with Tag Throttling

This block turns one large DMA read command, given as a start address and a byte length, into a stream of memory read request descriptors for a PCI Express requester. Each descriptor is capped by a 3-bit size code taken from the device control settings. No descriptor crosses a 4 KB address boundary. The descriptors of one command come out in increasing address order, and together they cover the command exactly.

Each descriptor carries a header tag taken from a pool of reusable tags, so the completions that come back can be matched to their request. A tag stays busy until the completion side reports, through the tag-return input, that every byte of that request has arrived. When every tag is busy, issuing stops. The maximum payload size does not bound the length of a read request, so only the read request size code reaches this block.

Top module: `rd_req_splitter`

## Requirements
- R1: The size code `mrrs_code` selects the cap on a request's length: code n from 0 to 5 gives 128 << n bytes (000 gives 128, 001 gives 256, 011 gives 1024, 101 gives 4096).
- R2: Every request has a nonzero length no larger than the decoded cap. The requests of one command have contiguous, increasing addresses, and their lengths add up to the command length.
- R3: No request crosses a 4 KB boundary. A piece that would cross one ends at the boundary, and the next request starts there.
- R4: While all NTAGS tags are outstanding, `req_valid` stays low.
- R5: Each request carries the lowest-numbered free tag. No tag is handed out while it is outstanding.
- R6: A tag returned through `tag_ret_valid`/`tag_ret_id` at one clock edge can be carried by a request that is offered in the next cycle.
- R7: After a nonzero-length command is accepted, `cmd_ready` is low until the clock edge at which the command's last request is accepted. From the next cycle it is high again.
- R8: A zero-length command is accepted, issues no request, and leaves `cmd_ready` high.
- R9: The reserved size codes 110 and 111 act as a 4096-byte cap.
- R10: After reset, `cmd_ready` is 1, `req_valid` is 0, and all tags are free, so the first request carries tag 0.
- R11: While `req_valid` is high and `req_ready` is low, the request stays valid and `req_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Read command offered |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_addr | input | ADDR_W | Start byte address of the command |
| cmd_len | input | LEN_W | Byte length of the command |
| mrrs_code | input | 3 | Maximum read request size code |
| tag_ret_valid | input | 1 | A request's completion data has fully arrived |
| tag_ret_id | input | TAG_W | Tag being returned to the pool |
| req_valid | output | 1 | Request descriptor offered |
| req_ready | input | 1 | Downstream takes the descriptor |
| req_addr | output | ADDR_W | Request start byte address |
| req_len | output | 13 | Request length in bytes (1 to 4096) |
| req_tag | output | TAG_W | Header tag of the request |

## Verification
The bench walks commands that start just below a 4 KB boundary, commands that end exactly on one, and commands that use the reserved size codes. A design that ignores the boundary would issue a piece that straddles it. A design that decodes codes 110 and 111 by shifting would produce a wrong length. It also fills the whole tag pool to check that issuing stops and does not reuse a busy tag. It then returns tags out of order to check that the lowest free tag wins and that a returned tag is usable in the very next cycle, which exposes a design with an extra pipeline stage in its free list. A zero-length command checks that the block neither hangs with `cmd_ready` low nor issues a request of length zero.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

   localparam int unsigned PAGE_BYTES = 4096;
   localparam int unsigned REQ_LEN_W  = 13;

   typedef enum logic {
      ST_IDLE,
      ST_ISSUE
   } rrs_state_e;

   // Size code to byte cap; the two reserved codes saturate at one page.
   function automatic logic [REQ_LEN_W-1:0] rrs_size_bytes(input logic [2:0] code);
      logic [REQ_LEN_W-1:0] bytes;
      case (code)
         3'b110, 3'b111: bytes = REQ_LEN_W'(PAGE_BYTES);
         default:        bytes = REQ_LEN_W'(128) << code;
      endcase
      return bytes;
   endfunction

endpackage

// File: rtl/rrs_tag_pool.sv
module rrs_tag_pool #(
   parameter int NTAGS = 32,
   parameter int TAG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_i,
   input  logic             rel_valid_i,
   input  logic [TAG_W-1:0] rel_tag_i,
   output logic             avail_o,
   output logic [TAG_W-1:0] tag_o
);

   logic [NTAGS-1:0] free_q;

   // One flag per tag: a return sets it, an allocation clears it.
   for (genvar g = 0; g < NTAGS; g++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)
            free_q[g] <= 1'b1;
         else if (rel_valid_i && rel_tag_i == TAG_W'(g))
            free_q[g] <= 1'b1;
         else if (alloc_i && tag_o == TAG_W'(g))
            free_q[g] <= 1'b0;
      end
   end

   // Lowest free index wins.
   always_comb begin
      tag_o = '0;
      for (int i = NTAGS - 1; i >= 0; i--) begin
         if (free_q[i]) tag_o = TAG_W'(i);
      end
   end

   assign avail_o = |free_q;

endmodule

// File: rtl/rrs_chunk_calc.sv
module rrs_chunk_calc
   import rrs_pkg::*;
#(
   parameter int LEN_W = 24
) (
   input  logic [11:0]          page_off_i,
   input  logic [LEN_W-1:0]     rem_i,
   input  logic [2:0]           code_i,
   output logic [REQ_LEN_W-1:0] chunk_o
);

   logic [REQ_LEN_W-1:0] room;
   logic [REQ_LEN_W-1:0] cap;
   logic [REQ_LEN_W-1:0] lim;

   always_comb begin
      room = REQ_LEN_W'(PAGE_BYTES) - {1'b0, page_off_i};
      cap  = rrs_size_bytes(code_i);
      lim  = (room < cap) ? room : cap;
      if (rem_i < LEN_W'(lim))
         chunk_o = rem_i[REQ_LEN_W-1:0];
      else
         chunk_o = lim;
   end

endmodule

// File: rtl/rd_req_splitter.sv
module rd_req_splitter
   import rrs_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 24,
   parameter int NTAGS  = 32,
   localparam int TAG_W = (NTAGS > 1) ? $clog2(NTAGS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   output logic                 cmd_ready,
   input  logic [ADDR_W-1:0]    cmd_addr,
   input  logic [LEN_W-1:0]     cmd_len,
   input  logic [2:0]           mrrs_code,
   input  logic                 tag_ret_valid,
   input  logic [TAG_W-1:0]     tag_ret_id,
   output logic                 req_valid,
   input  logic                 req_ready,
   output logic [ADDR_W-1:0]    req_addr,
   output logic [REQ_LEN_W-1:0] req_len,
   output logic [TAG_W-1:0]     req_tag
);

   initial begin
      assert (NTAGS >= 2) else $error("NTAGS must be at least 2");
      assert (LEN_W >= REQ_LEN_W) else $error("LEN_W must hold one page");
      assert (ADDR_W >= 12) else $error("ADDR_W must cover a page offset");
   end

   rrs_state_e           state_q;
   logic [ADDR_W-1:0]    addr_q;
   logic [LEN_W-1:0]     rem_q;
   logic [REQ_LEN_W-1:0] chunk;
   logic                 tag_avail;
   logic                 fire;
   logic                 cmd_take;

   rrs_chunk_calc #(.LEN_W(LEN_W)) i_chunk (
      .page_off_i (addr_q[11:0]),
      .rem_i      (rem_q),
      .code_i     (mrrs_code),
      .chunk_o    (chunk)
   );

   rrs_tag_pool #(.NTAGS(NTAGS), .TAG_W(TAG_W)) i_pool (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_i     (fire),
      .rel_valid_i (tag_ret_valid),
      .rel_tag_i   (tag_ret_id),
      .avail_o     (tag_avail),
      .tag_o       (req_tag)
   );

   assign cmd_ready = (state_q == ST_IDLE);
   assign cmd_take  = cmd_valid && cmd_ready && (cmd_len != '0);
   assign req_valid = (state_q == ST_ISSUE) && tag_avail;
   assign fire      = req_valid && req_ready;
   assign req_addr  = addr_q;
   assign req_len   = chunk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         rem_q   <= '0;
      end else if (cmd_take) begin
         state_q <= ST_ISSUE;
         addr_q  <= cmd_addr;
         rem_q   <= cmd_len;
      end else if (fire) begin
         addr_q <= addr_q + ADDR_W'(chunk);
         rem_q  <= rem_q - LEN_W'(chunk);
         if (rem_q == LEN_W'(chunk)) state_q <= ST_IDLE;
      end
   end

endmodule

// File: rtl/rrs_checker.sv
module rrs_checker
   import rrs_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 24,
   parameter int NTAGS  = 32,
   parameter int TAG_W  = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cmd_valid,
   input logic                 cmd_ready,
   input logic [LEN_W-1:0]     cmd_len,
   input logic [2:0]           mrrs_code,
   input logic                 tag_ret_valid,
   input logic [TAG_W-1:0]     tag_ret_id,
   input logic                 req_valid,
   input logic                 req_ready,
   input logic [ADDR_W-1:0]    req_addr,
   input logic [REQ_LEN_W-1:0] req_len,
   input logic [TAG_W-1:0]     req_tag
);

   // Outstanding tags as seen at the ports.
   logic [NTAGS-1:0] busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= '0;
      end else begin
         for (int i = 0; i < NTAGS; i++) begin
            if (tag_ret_valid && tag_ret_id == TAG_W'(i))
               busy_q[i] <= 1'b0;
            else if (req_valid && req_ready && req_tag == TAG_W'(i))
               busy_q[i] <= 1'b1;
         end
      end
   end

   AST_LEN_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_len != '0) && (req_len <= rrs_size_bytes(mrrs_code))); // R2

   AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ({2'b00, req_addr[11:0]} + {1'b0, req_len}) <= 14'd4096); // R3

   AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (&busy_q) |-> !req_valid); // R4

   AST_TAG_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !busy_q[req_tag]); // R5

   AST_CMD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_len != '0) |=> !cmd_ready); // R7

   AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_len == '0) |=> (cmd_ready && !req_valid)); // R8

   AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr))); // R11

endmodule

bind rd_req_splitter rrs_checker #(
   .ADDR_W (ADDR_W),
   .LEN_W  (LEN_W),
   .NTAGS  (NTAGS),
   .TAG_W  (TAG_W)
) i_rrs_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_valid     (cmd_valid),
   .cmd_ready     (cmd_ready),
   .cmd_len       (cmd_len),
   .mrrs_code     (mrrs_code),
   .tag_ret_valid (tag_ret_valid),
   .tag_ret_id    (tag_ret_id),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_addr      (req_addr),
   .req_len       (req_len),
   .req_tag       (req_tag)
);

// File: tb/test_rd_req_splitter.sv
module test_rd_req_splitter;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 32;
   localparam int LEN_W  = 24;
   localparam int NTAGS  = 32;
   localparam int TAG_W  = 5;

   typedef struct packed {
      logic [31:0] a;
      logic [23:0] l;
      logic [2:0]  c;
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VECS [NVEC] = '{
      '{a: 32'h0000_0000, l: 24'd100,  c: 3'd0},   // single short piece
      '{a: 32'h0000_0000, l: 24'd512,  c: 3'd0},   // four 128-byte pieces
      '{a: 32'h0000_0F80, l: 24'd512,  c: 3'd3},   // cut at page edge
      '{a: 32'h0000_1000, l: 24'd4096, c: 3'd5},   // one full page
      '{a: 32'h0000_0010, l: 24'd5000, c: 3'd7},   // reserved code, page cut
      '{a: 32'h0000_0200, l: 24'd1000, c: 3'd1},   // 256-byte pieces, odd tail
      '{a: 32'h0000_2000, l: 24'd4096, c: 3'd6},   // reserved code
      '{a: 32'h0000_3F00, l: 24'd600,  c: 3'd2}    // page cut then tail
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic              cmd_ready;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic [LEN_W-1:0]  cmd_len = '0;
   logic [2:0]        mrrs_code = 3'd0;
   logic              tag_ret_valid = 1'b0;
   logic [TAG_W-1:0]  tag_ret_id = '0;
   logic              req_valid;
   logic              req_ready = 1'b0;
   logic [ADDR_W-1:0] req_addr;
   logic [12:0]       req_len;
   logic [TAG_W-1:0]  req_tag;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rd_req_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NTAGS(NTAGS)) i_rd_req_splitter (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_addr(cmd_addr), .cmd_len(cmd_len), .mrrs_code(mrrs_code),
      .tag_ret_valid(tag_ret_valid), .tag_ret_id(tag_ret_id),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_len(req_len), .req_tag(req_tag)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int cap_of(input logic [2:0] c);
      return (c >= 3'd6) ? 4096 : (128 << c);
   endfunction

   task automatic send_cmd(input logic [31:0] a, input logic [23:0] l);
      @(negedge clk);
      cmd_addr  = a;
      cmd_len   = l;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic ret_tag(input int t);
      @(negedge clk);
      tag_ret_valid = 1'b1;
      tag_ret_id    = TAG_W'(t);
      @(negedge clk);
      tag_ret_valid = 1'b0;
   endtask

   // Collect n pieces with req_ready high, comparing against the page/cap rule.
   task automatic collect(inout longint ea, inout longint er, input int cap,
                          input int n, input int first_tag);
      for (int p = 0; p < n; p++) begin
         int guard = 0;
         longint room, exp_len;
         while (!req_valid && guard < 50) begin
            @(negedge clk);
            guard++;
         end
         room    = 4096 - (ea % 4096);
         exp_len = er;
         if (cap < exp_len) exp_len = cap;
         if (room < exp_len) exp_len = room;
         check(req_valid, "R2 piece offered", req_valid, 1);
         check(req_addr == ea[31:0], "R2/R3 piece address", req_addr, ea);
         check(req_len == exp_len[12:0], "R1/R2/R3/R9 piece length", req_len, exp_len);
         check(req_tag == TAG_W'(first_tag + p), "R5 lowest free tag", req_tag, first_tag + p);
         if (er != exp_len)
            check(!cmd_ready, "R7 cmd_ready low while splitting", cmd_ready, 0);
         ea += exp_len;
         er -= exp_len;
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      check(cmd_ready == 1'b1, "R10 cmd_ready after reset", cmd_ready, 1);
      check(req_valid == 1'b0, "R10 req_valid after reset", req_valid, 0);

      // Vector walk: R1 R2 R3 R5 R7 R9
      for (int v = 0; v < NVEC; v++) begin
         longint ea, er;
         int n, cap;
         ea = VECS[v].a;
         er = VECS[v].l;
         cap = cap_of(VECS[v].c);
         mrrs_code = VECS[v].c;
         // count pieces from the rule
         n = 0;
         begin
            longint ta, tr;
            ta = ea; tr = er;
            while (tr > 0) begin
               longint s;
               s = tr;
               if (cap < s) s = cap;
               if (4096 - (ta % 4096) < s) s = 4096 - (ta % 4096);
               ta += s; tr -= s; n++;
            end
         end
         req_ready = 1'b1;
         send_cmd(VECS[v].a, VECS[v].l);
         collect(ea, er, cap, n, 0);
         req_ready = 1'b0;
         check(er == 0, "R2 lengths sum to command", er, 0);
         check(cmd_ready, "R7 cmd_ready back after last piece", cmd_ready, 1);
         check(!req_valid, "R2 no extra piece", req_valid, 0);
         for (int t = 0; t < n; t++) ret_tag(t);
      end

      // R8: zero-length command
      req_ready = 1'b1;
      send_cmd(32'h0000_0400, 24'd0);
      for (int k = 0; k < 3; k++) begin
         check(cmd_ready, "R8 zero length keeps cmd_ready", cmd_ready, 1);
         check(!req_valid, "R8 zero length issues nothing", req_valid, 0);
         @(negedge clk);
      end

      // Tag exhaustion: R4 R5 R6 R11
      begin
         longint ea, er;
         mrrs_code = 3'd0;
         ea = 0;
         er = 40 * 128;
         req_ready = 1'b1;
         send_cmd(32'h0, 24'(40 * 128));
         collect(ea, er, 128, 32, 0);
         for (int k = 0; k < 3; k++) begin
            check(!req_valid, "R4 stall with all tags busy", req_valid, 0);
            @(negedge clk);
         end
         req_ready = 1'b0;
         ret_tag(5);
         check(req_valid, "R6 returned tag usable next cycle", req_valid, 1);
         check(req_tag == 5, "R6 returned tag reused", req_tag, 5);
         check(req_addr == 32'd4096, "R2 address after stall", req_addr, 4096);
         @(negedge clk);
         check(req_valid && req_addr == 32'd4096, "R11 held while not ready", req_addr, 4096);
         ret_tag(3);
         check(req_tag == 3, "R5 lower returned tag wins", req_tag, 3);
         check(req_addr == 32'd4096, "R11 address held", req_addr, 4096);
         req_ready = 1'b1;
         @(negedge clk);
         check(req_valid && req_tag == 5, "R5 next free tag", req_tag, 5);
         check(req_addr == 32'd4224, "R2 contiguous address", req_addr, 4224);
         @(negedge clk);
         check(!req_valid, "R4 stall again", req_valid, 0);
         req_ready = 1'b0;
         for (int t = 0; t < NTAGS; t++) ret_tag(t);
         req_ready = 1'b1;
         ea = 34 * 128;
         er = 6 * 128;
         collect(ea, er, 128, 6, 0);
         req_ready = 1'b0;
         check(er == 0, "R2 long command completes", er, 0);
         check(cmd_ready, "R7 ready after long command", cmd_ready, 1);
         for (int t = 0; t < 6; t++) ret_tag(t);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule